// File: doc/BRIEF.md
# Camera Packet Header ECC Unit

This unit protects and checks the 24-bit header of a camera-serial-link packet. Three header bytes are joined into one protected word, and a 6-bit Hamming-style code is computed over it with a fixed, irregular parity matrix. The code travels in an 8-bit field whose top two bits are always zero.

On the receive side, the unit compares the code it computes with the received code byte. It reports the syndrome and sorts the header into one of three outcomes:
- clean;
- corrected, meaning a single-bit error was fixed, either in the header or in the code byte;
- uncorrectable.

It also returns the header after any correction.

A parameter selects whether the results pass through one output register. When they do, the results carry a valid strobe one clock behind the input strobe. Header parsing logic uses the unit between the lane merger and the packet decoder. A transmitter can use only the computed code output.

Top module: `ecc_hdr_unit`

## Requirements
- R1: The protected word has the first header byte in bits 23..16, the second in bits 15..8 and the third in bits 7..0. A word holding only bit 16 gives code 0x31. A word holding only bit 0 gives code 0x07.
- R2: Each code bit is the XOR of a fixed set of word bits. Code bit 5 uses bits 10–19 and 21, 22, 23. Bit 4 uses 4–9, 16–20, 22 and 23. Bit 3 uses 1, 2, 3, 7, 8, 9, 13, 14, 15, 19, 20, 21 and 23. Bit 2 uses 0, 2, 3, 5, 6, 9, 11, 12, 15, 18, 20, 21 and 22. Bit 1 uses 0, 1, 3, 4, 6, 8, 10, 12, 14, 17, 20, 21, 22 and 23. Bit 0 uses 0, 1, 2, 4, 5, 7, 10, 11, 13, 16, 20–23. The 8-bit code output has bits 7..6 at zero.
- R3: A received code byte with bit 7 or bit 6 set is reported as uncorrectable, and the header passes out unchanged.
- R4: The syndrome equals the computed code XOR received code bits 5..0. A zero syndrome with clean top bits raises the clean flag, and the header passes out unchanged.
- R5: Every valid result has exactly one of the clean, corrected and uncorrectable flags high.
- R6: A syndrome equal to the parity column of one word bit flips that bit in the output header and raises the corrected flag.
- R7: A syndrome with exactly one bit set raises the corrected flag, and the header passes out unchanged.
- R8: Any other nonzero syndrome raises the uncorrectable flag, and the header passes out unchanged.
- R9: With the output register enabled (default), every result appears one clock after its inputs. The output valid follows the input valid by one clock, and reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input header and code byte are valid |
| hdr_b0 | input | 8 | First header byte (word bits 23..16) |
| hdr_b1 | input | 8 | Second header byte (word bits 15..8) |
| hdr_b2 | input | 8 | Third header byte (word bits 7..0) |
| rx_ecc | input | 8 | Received code byte |
| out_valid | output | 1 | Results are valid |
| calc_ecc | output | 8 | Code computed over the input header, bits 7..6 zero |
| syndrome | output | 6 | Computed code XOR received code bits 5..0 |
| hdr_ok | output | 1 | Header and code agree |
| hdr_fixed | output | 1 | One bit error was corrected |
| hdr_bad | output | 1 | Error cannot be corrected |
| hdr_out | output | 24 | Header word after correction |

## Verification
The unit is tried with clean random headers, random headers with one of the 24 word bits flipped, and random headers with one of the 6 code bits flipped. It is also tried with two word bits flipped and with a pad bit set in the code byte.

Clean headers separate the row equations and the byte order. Single word flips test every parity column and the bit it maps to. Single code flips confirm that the header is left alone when only the code byte is wrong. Double flips and pad errors show that no even-weight syndrome or malformed code byte is ever "corrected".

// File: rtl/ecc_hdr_pkg.sv
// Package: shared widths, parity matrix columns and the result record for the
// header ECC unit. Assumes a fixed 24-bit header and a 6-bit code.
package ecc_hdr_pkg;
    localparam int HDR_W  = 24;
    localparam int ECC_W  = 6;
    localparam int BYTE_W = 8;
    localparam int PAD_W  = BYTE_W - ECC_W;

    // Parity column of word bit i: which code bits that word bit feeds.
    function automatic logic [ECC_W-1:0] col_of(input int i);
        logic [ECC_W-1:0] c;
        case (i)
            0:  c = 6'h07;  1:  c = 6'h0B;  2:  c = 6'h0D;  3:  c = 6'h0E;
            4:  c = 6'h13;  5:  c = 6'h15;  6:  c = 6'h16;  7:  c = 6'h19;
            8:  c = 6'h1A;  9:  c = 6'h1C;  10: c = 6'h23;  11: c = 6'h25;
            12: c = 6'h26;  13: c = 6'h29;  14: c = 6'h2A;  15: c = 6'h2C;
            16: c = 6'h31;  17: c = 6'h32;  18: c = 6'h34;  19: c = 6'h38;
            20: c = 6'h1F;  21: c = 6'h2F;  22: c = 6'h37;  23: c = 6'h3B;
            default: c = '0;
        endcase
        return c;
    endfunction

    // Row mask of code bit r: the word bits it sums, derived from the columns.
    function automatic logic [HDR_W-1:0] row_mask(input int r);
        logic [HDR_W-1:0] m;
        logic [ECC_W-1:0] c;
        m = '0;
        for (int i = 0; i < HDR_W; i++) begin
            c = col_of(i);
            m[i] = c[r];
        end
        return m;
    endfunction

    typedef struct packed {
        logic [BYTE_W-1:0] ecc;
        logic [ECC_W-1:0]  syn;
        logic              ok;
        logic              fix;
        logic              bad;
        logic [HDR_W-1:0]  hdr;
    } hdr_res_t;
endpackage

// File: rtl/ecc_hdr_encoder.sv
// Encoder: computes the 6-bit parity of a 24-bit header word.
// Assumes the word is already assembled; purely combinational.
module ecc_hdr_encoder
    import ecc_hdr_pkg::*;
(
    input  logic [HDR_W-1:0] word,
    output logic [ECC_W-1:0] par
);
    // One XOR tree per code bit, masked by its matrix row.
    for (genvar r = 0; r < ECC_W; r++) begin : g_row
        localparam logic [HDR_W-1:0] MASK = row_mask(r);
        assign par[r] = ^(word & MASK);
    end
endmodule

// File: rtl/ecc_hdr_decoder.sv
// Decoder: forms the syndrome, classifies it and corrects one word bit.
// Assumes par_calc is the encoder output for the same word.
module ecc_hdr_decoder
    import ecc_hdr_pkg::*;
(
    input  logic [HDR_W-1:0]  word,
    input  logic [ECC_W-1:0]  par_calc,
    input  logic [BYTE_W-1:0] rx_ecc,
    output hdr_res_t          res
);
    logic [ECC_W-1:0] syn;
    logic [HDR_W-1:0] hit;
    logic             pad_err;
    logic             data_hit;
    logic             ecc_hit;

    assign syn     = par_calc ^ rx_ecc[ECC_W-1:0];
    assign pad_err = |rx_ecc[BYTE_W-1:ECC_W];

    // Match the syndrome against every word bit's column.
    for (genvar i = 0; i < HDR_W; i++) begin : g_col
        localparam logic [ECC_W-1:0] COL = col_of(i);
        assign hit[i] = (syn == COL);
    end

    assign data_hit = |hit;
    assign ecc_hit  = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

    // Classify the header and apply the single-bit fix.
    always_comb begin
        res.ecc = {{PAD_W{1'b0}}, par_calc};
        res.syn = syn;
        res.ok  = 1'b0;
        res.fix = 1'b0;
        res.bad = 1'b0;
        res.hdr = word;
        if (pad_err) begin
            res.bad = 1'b1;
        end else if (syn == '0) begin
            res.ok = 1'b1;
        end else if (data_hit) begin
            res.fix = 1'b1;
            res.hdr = word ^ hit;
        end else if (ecc_hit) begin
            res.fix = 1'b1;
        end else begin
            res.bad = 1'b1;
        end
    end
endmodule

// File: rtl/ecc_hdr_outreg.sv
// Output stage: registers the result and valid strobe, or passes them through.
// Assumes a synchronous active-low reset; REG_OUT picks the variant.
module ecc_hdr_outreg
    import ecc_hdr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  hdr_res_t d,
    output hdr_res_t q,
    output logic     out_valid
);
    if (REG_OUT) begin : g_reg
        hdr_res_t q_r;
        logic     v_r;
        // Capture result and strobe on every clock; reset clears both.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_r <= '0;
                v_r <= 1'b0;
            end else begin
                q_r <= d;
                v_r <= in_valid;
            end
        end
        assign q         = q_r;
        assign out_valid = v_r;
    end else begin : g_comb
        assign q         = d;
        assign out_valid = in_valid;
    end
endmodule

// File: rtl/ecc_hdr_unit.sv
// Top: header ECC generate-and-check unit. Joins three header bytes into
// the protected word, encodes, decodes against the received code byte
// and presents results, optionally through one register stage.
module ecc_hdr_unit
    import ecc_hdr_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] hdr_b0,
    input  logic [BYTE_W-1:0] hdr_b1,
    input  logic [BYTE_W-1:0] hdr_b2,
    input  logic [BYTE_W-1:0] rx_ecc,
    output logic              out_valid,
    output logic [BYTE_W-1:0] calc_ecc,
    output logic [ECC_W-1:0]  syndrome,
    output logic              hdr_ok,
    output logic              hdr_fixed,
    output logic              hdr_bad,
    output logic [HDR_W-1:0]  hdr_out
);
    logic [HDR_W-1:0] word;
    logic [ECC_W-1:0] par;
    hdr_res_t         res_c;
    hdr_res_t         res_q;

    assign word = {hdr_b0, hdr_b1, hdr_b2};

    ecc_hdr_encoder u_enc (.word(word), .par(par));

    ecc_hdr_decoder u_dec (.word(word), .par_calc(par), .rx_ecc(rx_ecc), .res(res_c));

    ecc_hdr_outreg #(.REG_OUT(REG_OUT)) u_out (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .d(res_c), .q(res_q), .out_valid(out_valid)
    );

    assign calc_ecc  = res_q.ecc;
    assign syndrome  = res_q.syn;
    assign hdr_ok    = res_q.ok;
    assign hdr_fixed = res_q.fix;
    assign hdr_bad   = res_q.bad;
    assign hdr_out   = res_q.hdr;
endmodule

// File: rtl/ecc_hdr_unit_chk.sv
// Checker for ecc_hdr_unit: relates flags, syndrome and output header to the
// inputs one clock earlier (registered variant) or the same cycle.
module ecc_hdr_unit_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [7:0]  hdr_b0,
    input logic [7:0]  hdr_b1,
    input logic [7:0]  hdr_b2,
    input logic [7:0]  rx_ecc,
    input logic        out_valid,
    input logic [7:0]  calc_ecc,
    input logic [5:0]  syndrome,
    input logic        hdr_ok,
    input logic        hdr_fixed,
    input logic        hdr_bad,
    input logic [23:0] hdr_out
);
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> calc_ecc[7:6] == 2'b00); // R2
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({hdr_ok, hdr_fixed, hdr_bad})); // R5
    AST_OK_ZERO_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && hdr_ok |-> syndrome == 6'd0); // R4
    AST_FIX_ODD_SYN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && hdr_fixed |-> $countones(syndrome) % 2 == 1); // R6

    if (REG_OUT) begin : g_reg_chk
        AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R9
        AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid); // R9
        AST_PAD_BAD: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid && (rx_ecc[7:6] != 2'b00) |=> hdr_bad); // R3
        AST_ONE_BIT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> $countones(hdr_out ^ $past({hdr_b0, hdr_b1, hdr_b2})) <= 1); // R6
        AST_BAD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !hdr_fixed |-> hdr_out == $past({hdr_b0, hdr_b1, hdr_b2})); // R8
    end else begin : g_comb_chk
        // Same-cycle check of the uncorrected header path.
        always_comb begin
            if (rst_n && out_valid && !hdr_fixed)
                AST_BAD_KEEP: assert (hdr_out == {hdr_b0, hdr_b1, hdr_b2}); // R8
        end
    end
endmodule

bind ecc_hdr_unit ecc_hdr_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .hdr_b0(hdr_b0), .hdr_b1(hdr_b1), .hdr_b2(hdr_b2), .rx_ecc(rx_ecc),
    .out_valid(out_valid), .calc_ecc(calc_ecc), .syndrome(syndrome),
    .hdr_ok(hdr_ok), .hdr_fixed(hdr_fixed), .hdr_bad(hdr_bad), .hdr_out(hdr_out)
);

// File: tb/tb_ecc_hdr_unit.sv
// Bench: directed corner cases plus seeded random headers and error kinds,
// checked against a reference built from the row equations.
module tb_ecc_hdr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  hdr_b0 = '0, hdr_b1 = '0, hdr_b2 = '0, rx_ecc = '0;
    logic        out_valid;
    logic [7:0]  calc_ecc;
    logic [5:0]  syndrome;
    logic        hdr_ok, hdr_fixed, hdr_bad;
    logic [23:0] hdr_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ecc_hdr_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .hdr_b0(hdr_b0), .hdr_b1(hdr_b1), .hdr_b2(hdr_b2), .rx_ecc(rx_ecc),
        .out_valid(out_valid), .calc_ecc(calc_ecc), .syndrome(syndrome),
        .hdr_ok(hdr_ok), .hdr_fixed(hdr_fixed), .hdr_bad(hdr_bad), .hdr_out(hdr_out)
    );

    // Reference code from the row equations (R2).
    function automatic logic [5:0] ref_ecc(input logic [23:0] d);
        logic [5:0] e;
        e[5] = (^d[19:10]) ^ d[21] ^ d[22] ^ d[23];
        e[4] = (^d[9:4]) ^ (^d[20:16]) ^ d[22] ^ d[23];
        e[3] = d[1]^d[2]^d[3]^d[7]^d[8]^d[9]^d[13]^d[14]^d[15]^d[19]^d[20]^d[21]^d[23];
        e[2] = d[0]^d[2]^d[3]^d[5]^d[6]^d[9]^d[11]^d[12]^d[15]^d[18]^d[20]^d[21]^d[22];
        e[1] = d[0]^d[1]^d[3]^d[4]^d[6]^d[8]^d[10]^d[12]^d[14]^d[17]^d[20]^d[21]^d[22]^d[23];
        e[0] = d[0]^d[1]^d[2]^d[4]^d[5]^d[7]^d[10]^d[11]^d[13]^d[16]^d[20]^d[21]^d[22]^d[23];
        return e;
    endfunction

    // Expected {valid, ecc, syn, ok, fix, bad, hdr} per R3..R8.
    function automatic logic [41:0] ref_out(input logic [23:0] d, input logic [7:0] rx);
        logic [5:0]  e, s;
        logic        ok, fx, bd;
        logic [23:0] h;
        e = ref_ecc(d);
        s = e ^ rx[5:0];
        ok = 1'b0; fx = 1'b0; bd = 1'b0; h = d;
        if (rx[7:6] != 2'b00) bd = 1'b1;
        else if (s == 6'd0) ok = 1'b1;
        else begin
            for (int i = 0; i < 24; i++)
                if (ref_ecc(24'd1 << i) == s) begin fx = 1'b1; h = d ^ (24'd1 << i); end
            if (!fx) begin
                if ($countones(s) == 1) fx = 1'b1;
                else bd = 1'b1;
            end
        end
        return {1'b1, 2'b00, e, s, ok, fx, bd, h};
    endfunction

    task automatic check(input string req, input logic [41:0] got, input logic [41:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Drive one header at a falling edge, compare at the next falling edge.
    task automatic apply(input string req, input logic [23:0] d, input logic [7:0] rx);
        @(negedge clk);
        in_valid = 1'b1;
        {hdr_b0, hdr_b1, hdr_b2} = d;
        rx_ecc = rx;
        @(negedge clk);
        check(req, {out_valid, calc_ecc, syndrome, hdr_ok, hdr_fixed, hdr_bad, hdr_out},
              ref_out(d, rx));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [23:0] base;
        logic [7:0]  rxv;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset", {41'd0, out_valid}, 42'd0);
        rst_n = 1'b1;

        // R1: byte order and known single-bit codes.
        apply("R1", 24'h010000, 8'h31);
        check("R1 bit16 code", {34'd0, calc_ecc}, 42'h31);
        apply("R1", 24'h000001, 8'h07);
        check("R1 bit0 code", {34'd0, calc_ecc}, 42'h07);
        apply("R4 zero", 24'h000000, 8'h00);

        // R6: every word bit flipped once.
        base = 24'hA5C3F0;
        for (int i = 0; i < 24; i++)
            apply("R6", base ^ (24'd1 << i), {2'b00, ref_ecc(base)});
        // R7: every code bit flipped once.
        for (int j = 0; j < 6; j++)
            apply("R7", base, {2'b00, ref_ecc(base) ^ (6'd1 << j)});
        // R8: double word-bit errors.
        apply("R8", base ^ 24'h000003, {2'b00, ref_ecc(base)});
        apply("R8", base ^ 24'h810000, {2'b00, ref_ecc(base)});
        // R3: pad bits set.
        apply("R3", base, {2'b01, ref_ecc(base)});
        apply("R3", base, {2'b10, ref_ecc(base)});

        // R9: valid strobe follows input one clock later.
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); check("R9 drop", {41'd0, out_valid}, 42'd0);
        in_valid = 1'b1;
        @(negedge clk); check("R9 rise", {41'd0, out_valid}, 42'd1);

        // Random mix: clean R1/R2/R4, word R6, code R7, double R8, pad R3.
        for (int k = 0; k < 600; k++) begin
            int kind;
            base = 24'($urandom);
            rxv  = {2'b00, ref_ecc(base)};
            kind = int'($urandom_range(0, 4));
            case (kind)
                1: base = base ^ (24'd1 << $urandom_range(0, 23));
                2: rxv  = rxv ^ (8'd1 << $urandom_range(0, 5));
                3: base = base ^ (24'd1 << $urandom_range(0, 11)) ^ (24'd1 << $urandom_range(12, 23));
                4: rxv  = rxv | (8'h40 << $urandom_range(0, 1));
                default: ;
            endcase
            apply("R1/R2/R3/R4/R5/R6/R7/R8 random", base, rxv);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule